// File: doc/BRIEF.md
# Two-Operand Add/Subtract Sequencer

This block gathers two small unsigned operands from an operator, one after the other, and then combines them. A run starts when the active-low start input is seen low while the block is idle. The operation select is captured at that moment and kept for the whole run. The block then clears its accumulator. For each operand it lights a request output. The operator sets the switches and raises a ready input. The block drops the request, copies the switches into the operand register and, on the following cycle, writes the adder/subtracter output back into the accumulator.

The first operand is always added into the cleared accumulator. The second operand is added or subtracted according to the captured select, modulo 2^W. After the second write-back the block returns to idle and the accumulator keeps the answer until the next start. The controller states are IDLE, CLEAR, REQ1, LOAD1, ACC1, WAIT1, REQ2, LOAD2, ACC2 and DONE. Their transitions are:

- IDLE to CLEAR on start.
- CLEAR to REQ1 once ready is low.
- REQ1 to LOAD1 on ready.
- LOAD1 to ACC1 to WAIT1 unconditionally.
- WAIT1 to REQ2 once ready is low.
- REQ2 to LOAD2 on ready.
- LOAD2 to ACC2 to DONE to IDLE unconditionally.

Top module: `addsub_seq`

## Requirements
- R1: While the synchronous active-low reset is low at a clock edge, the block goes idle. After that edge req_data, en_a and en_b are 0, clr_b_n is 1 and result is 0.
- R2: A start_n low sampled in IDLE begins a run. The accumulator is cleared, so result reads 0 when req_data first rises.
- R3: While req_data is high, a ready sampled high makes req_data fall at the next edge. The operand register loads sw_data at the edge after that, and the accumulator is written at the edge after that.
- R4: req_data rises for an operand only after data_ready was seen low. A ready level held high therefore never loads a second operand.
- R5: The first operand is always added into zero, so after the first write-back result equals that operand.
- R6: After the second write-back, result is (first + second) mod 2^W when the captured select was 1, and (first - second) mod 2^W when it was 0. The result is due at the third edge after ready is sampled high in REQ2.
- R7: func_add is sampled only when the run starts. Changing it during the run does not change the result.
- R8: start_n is ignored while a run is in progress.
- R9: In each run, en_a and en_b are each high for exactly one cycle per operand, two cycles each in total, and never together. The first write-back uses add_sel = 1.
- R10: After the second write-back the block returns to idle with req_data low. result then holds its value until the next start.
- R11: clr_b_n is low only during the clear step of a run. When it is low, result is 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for controller and both registers |
| rst_n | input | 1 | Synchronous reset, active low |
| start_n | input | 1 | Start request, active low |
| func_add | input | 1 | Operation select: 1 add, 0 subtract |
| data_ready | input | 1 | Operator ready handshake |
| sw_data | input | W | Operand switches |
| req_data | output | 1 | Request indicator to the operator |
| en_a | output | 1 | Operand register load enable |
| en_b | output | 1 | Accumulator load enable |
| clr_b_n | output | 1 | Accumulator clear, active low |
| add_sel | output | 1 | Adder/subtracter select: 1 add, 0 subtract |
| result | output | W | Accumulator contents |

## Verification
Every controller output is decoded from the state register, so each one changes one edge after the input that causes it. Operand capture follows ready by two edges, and the accumulator follows ready by three edges. The bench raises ready at a falling edge and then samples at the falling edges that follow: req_data low after one edge, the first partial result after three, and the final answer three edges after the second ready. The pulse counts for en_a and en_b are gathered at falling edges over the whole run.

// File: rtl/addsub_seq_pkg.sv
package addsub_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_CLEAR = 4'd1,
        ST_REQ1  = 4'd2,
        ST_LOAD1 = 4'd3,
        ST_ACC1  = 4'd4,
        ST_WAIT1 = 4'd5,
        ST_REQ2  = 4'd6,
        ST_LOAD2 = 4'd7,
        ST_ACC2  = 4'd8,
        ST_DONE  = 4'd9
    } seq_state_e;

    typedef struct packed {
        logic req;
        logic load_a;
        logic load_b;
        logic clr_n;
        logic add;
    } seq_ctl_t;

    localparam seq_ctl_t CTL_QUIET = '{req: 1'b0, load_a: 1'b0, load_b: 1'b0,
                                       clr_n: 1'b1, add: 1'b1};

endpackage

// File: rtl/addsub_seq_reg.sv
module addsub_seq_reg #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/addsub_seq_alu.sv
module addsub_seq_alu #(
    parameter int W = 3
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         add,
    output logic [W-1:0] sum
);

    logic [W-1:0] rhs_x;
    logic [W-1:0] cin;

    assign rhs_x  = add ? rhs : ~rhs;
    assign cin[0] = ~add;

    // Ripple chain; the carry out of the top bit is dropped (modulo 2^W).
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i] = lhs[i] ^ rhs_x[i] ^ cin[i];
        if (i < W - 1) begin : g_carry
            assign cin[i+1] = (lhs[i] & rhs_x[i]) | (cin[i] & (lhs[i] ^ rhs_x[i]));
        end
    end

endmodule

// File: rtl/addsub_seq_ctrl.sv
module addsub_seq_ctrl
    import addsub_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_n,
    input  logic     func_add,
    input  logic     data_ready,
    output seq_ctl_t ctl
);

    seq_state_e state_q, state_d;
    logic       func_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Operation select, captured once per run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            func_q <= 1'b1;
        end else if (state_q == ST_IDLE && !start_n) begin
            func_q <= func_add;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!start_n)    state_d = ST_CLEAR;
            ST_CLEAR: if (!data_ready) state_d = ST_REQ1;
            ST_REQ1:  if (data_ready)  state_d = ST_LOAD1;
            ST_LOAD1:                  state_d = ST_ACC1;
            ST_ACC1:                   state_d = ST_WAIT1;
            ST_WAIT1: if (!data_ready) state_d = ST_REQ2;
            ST_REQ2:  if (data_ready)  state_d = ST_LOAD2;
            ST_LOAD2:                  state_d = ST_ACC2;
            ST_ACC2:                   state_d = ST_DONE;
            ST_DONE:                   state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // Outputs, decoded from the state alone
    always_comb begin
        ctl = CTL_QUIET;
        unique case (state_q)
            ST_IDLE:  ;
            ST_CLEAR: ctl.clr_n  = 1'b0;
            ST_REQ1:  ctl.req    = 1'b1;
            ST_LOAD1: ctl.load_a = 1'b1;
            ST_ACC1:  ctl.load_b = 1'b1;
            ST_WAIT1: ;
            ST_REQ2:  ctl.req    = 1'b1;
            ST_LOAD2: ctl.load_a = 1'b1;
            ST_ACC2: begin
                ctl.load_b = 1'b1;
                ctl.add    = func_q;
            end
            ST_DONE:  ;
            default:  ;
        endcase
    end

endmodule

// File: rtl/addsub_seq.sv
module addsub_seq
    import addsub_seq_pkg::*;
#(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_n,
    input  logic         func_add,
    input  logic         data_ready,
    input  logic [W-1:0] sw_data,
    output logic         req_data,
    output logic         en_a,
    output logic         en_b,
    output logic         clr_b_n,
    output logic         add_sel,
    output logic [W-1:0] result
);

    seq_ctl_t     ctl;
    logic [W-1:0] reg_a;
    logic [W-1:0] alu_out;

    addsub_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_n    (start_n),
        .func_add   (func_add),
        .data_ready (data_ready),
        .ctl        (ctl)
    );

    addsub_seq_reg #(.W(W)) u_reg_a (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (1'b1),
        .load  (ctl.load_a),
        .d     (sw_data),
        .q     (reg_a)
    );

    addsub_seq_alu #(.W(W)) u_alu (
        .lhs (result),
        .rhs (reg_a),
        .add (ctl.add),
        .sum (alu_out)
    );

    addsub_seq_reg #(.W(W)) u_reg_b (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (ctl.clr_n),
        .load  (ctl.load_b),
        .d     (alu_out),
        .q     (result)
    );

    assign req_data = ctl.req;
    assign en_a     = ctl.load_a;
    assign en_b     = ctl.load_b;
    assign clr_b_n  = ctl.clr_n;
    assign add_sel  = ctl.add;

endmodule

// File: rtl/addsub_seq_chk.sv
module addsub_seq_chk #(
    parameter int W = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         data_ready,
    input logic         req_data,
    input logic         en_a,
    input logic         en_b,
    input logic         clr_b_n,
    input logic [W-1:0] result
);

    AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) !(en_a && en_b)); // R9
    AST_ENA_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) en_a |=> !en_a); // R9
    AST_ENB_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) en_b |=> !en_b); // R9
    AST_ACC_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n) en_a |=> en_b); // R3
    AST_REQ_DROP:   assert property (@(posedge clk) disable iff (!rst_n)
                                     (req_data && data_ready) |=> !req_data); // R3
    AST_LOAD_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
                                     $rose(en_a) |-> ($past(req_data) && $past(data_ready))); // R3
    AST_REQ_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                                     $rose(req_data) |-> !$past(data_ready)); // R4
    AST_B_CLEAR:    assert property (@(posedge clk) disable iff (!rst_n)
                                     !clr_b_n |=> (result == '0)); // R11
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                                     (clr_b_n && !en_b) |=> $stable(result)); // R10

endmodule

bind addsub_seq addsub_seq_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_ready (data_ready),
    .req_data   (req_data),
    .en_a       (en_a),
    .en_b       (en_b),
    .clr_b_n    (clr_b_n),
    .result     (result)
);

// File: tb/addsub_seq_test.sv
module addsub_seq_test;

    localparam int W = 3;
    localparam int NV = 8;
    // Vector fields: {first[9:7], second[6:4], func[3], expected[2:0]}
    localparam logic [9:0] VEC [NV] = '{
        {3'd3, 3'd2, 1'b1, 3'd5},
        {3'd5, 3'd6, 1'b1, 3'd3},
        {3'd6, 3'd2, 1'b0, 3'd4},
        {3'd2, 3'd5, 1'b0, 3'd5},
        {3'd7, 3'd7, 1'b1, 3'd6},
        {3'd0, 3'd0, 1'b0, 3'd0},
        {3'd4, 3'd4, 1'b0, 3'd0},
        {3'd1, 3'd7, 1'b0, 3'd2}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_n = 1'b1;
    logic         func_add = 1'b1;
    logic         data_ready = 1'b0;
    logic [W-1:0] sw_data = '0;
    logic         req_data, en_a, en_b, clr_b_n, add_sel;
    logic [W-1:0] result;

    int checks = 0;
    int fails = 0;
    int ena_cnt = 0;
    int enb_cnt = 0;
    int both_cnt = 0;
    int add1_bad = 0;
    int acc_seen = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    addsub_seq #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start_n(start_n), .func_add(func_add),
        .data_ready(data_ready), .sw_data(sw_data), .req_data(req_data),
        .en_a(en_a), .en_b(en_b), .clr_b_n(clr_b_n), .add_sel(add_sel),
        .result(result)
    );

    always @(negedge clk) begin
        if (en_a) ena_cnt++;
        if (en_b) begin
            enb_cnt++;
            if (acc_seen == 0 && !add_sel) add1_bad++;
            acc_seen++;
        end
        if (en_a && en_b) both_cnt++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        ena_cnt = 0; enb_cnt = 0; both_cnt = 0; add1_bad = 0; acc_seen = 0;
    endtask

    task automatic wait_req(input string req);
        for (int i = 0; i < 64; i++) begin
            if (req_data) return;
            @(negedge clk);
        end
        check(1'b0, req, 0, 1);
    endtask

    task automatic pulse_start(input bit f);
        @(negedge clk);
        func_add = f;
        start_n = 1'b0;
        @(negedge clk);
        start_n = 1'b1;
    endtask

    // First operand: ready raised at a falling edge, partial result due three edges later
    task automatic first_operand(input logic [W-1:0] a);
        wait_req("R2");
        check(result == '0, "R2", result, 0);
        sw_data = a;
        data_ready = 1'b1;
        @(negedge clk);
        check(!req_data, "R3", req_data, 0);
        @(negedge clk);
        @(negedge clk);
        check(result == a, "R5", result, a);
        data_ready = 1'b0;
    endtask

    task automatic second_operand(input logic [W-1:0] b, input logic [W-1:0] exp, input string req);
        @(negedge clk);
        check(req_data, "R4", req_data, 1);
        sw_data = b;
        data_ready = 1'b1;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check(result == exp, req, result, exp);
        data_ready = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!req_data && !en_a && !en_b && clr_b_n && result == '0, "R1",
              {req_data, en_a, en_b, clr_b_n}, 4'b0001);

        // R6 vector walk, plus R9 enable counts per run
        for (int v = 0; v < NV; v++) begin
            clear_counts();
            pulse_start(VEC[v][3]);
            first_operand(VEC[v][9:7]);
            second_operand(VEC[v][6:4], VEC[v][2:0], "R6");
            check(ena_cnt == 2 && enb_cnt == 2 && both_cnt == 0 && add1_bad == 0, "R9",
                  ena_cnt * 100 + enb_cnt * 10 + both_cnt, 220);
        end

        // R10: result held in idle, request low
        repeat (10) @(negedge clk);
        check(result == 3'd2 && !req_data, "R10", result, 2);

        // R4: ready held high after first operand keeps the second request off
        pulse_start(1'b1);
        wait_req("R4");
        sw_data = 3'd3;
        data_ready = 1'b1;
        repeat (8) @(negedge clk);
        check(!req_data && result == 3'd3, "R4", req_data, 0);
        data_ready = 1'b0;
        second_operand(3'd1, 3'd4, "R4");

        // R7: select flipped during the run has no effect
        pulse_start(1'b0);
        func_add = 1'b1;
        first_operand(3'd5);
        second_operand(3'd1, 3'd4, "R7");

        // R8: start pulse in the middle of a run is ignored
        pulse_start(1'b1);
        first_operand(3'd2);
        start_n = 1'b0;
        @(negedge clk);
        start_n = 1'b1;
        check(req_data, "R8", req_data, 1);
        sw_data = 3'd3;
        data_ready = 1'b1;
        repeat (3) @(negedge clk);
        check(result == 3'd5, "R8", result, 5);
        data_ready = 1'b0;
        repeat (4) @(negedge clk);
        check(!req_data && result == 3'd5, "R8", result, 5);

        // R11: a new run clears the held result before the request
        pulse_start(1'b1);
        check(!clr_b_n, "R11", clr_b_n, 0);
        @(negedge clk);
        check(result == '0, "R11", result, 0);

        // R1: reset in the middle of a run
        first_operand(3'd6);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(!req_data && result == '0 && clr_b_n, "R1", result, 0);
        repeat (4) @(negedge clk);
        check(!req_data && result == '0, "R1", req_data, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule